// File: doc/BRIEF.md
# Banked Replicated Multiport Register File

This block is a register file of 64 entries, each 64 bits wide. It has three write ports and five read ports by default. Its storage is built only from simple banks with one read port and one write port. Each read port has its own full copy of the storage. Every committed write goes to all copies at once, so the copies always hold the same contents.

Multiple write ports come from partitioning. The register space is cut into equal sub-blocks, and each sub-block takes at most one write per clock. The upper address bits select the sub-block, and the remaining low bits select the entry inside it. The number of sub-blocks is a parameter, 4 or 8.

The issue logic is expected to keep simultaneous writes apart. When it does not, the block raises a conflict flag in that same cycle. The lowest-numbered write port then wins, and the other writes to that sub-block are dropped. Reads are synchronous, with one cycle of latency.

Top module: `mprf_banked`

## Requirements
- R1: After reset every register reads as zero on every read port. The conflict flag is low while no write is enabled.
- R2: Data written on an enabled write port at a clock edge is returned by a read of that address that is presented after the edge. The value appears one clock after the read address is sampled.
- R3: A read and a write to the same register at the same edge return the value held before the write. The new value is visible from the following read onward.
- R4: All read ports return identical data when they present the same address in the same cycle.
- R5: Enabled writes that target different sub-blocks in one cycle all commit. With 4 sub-blocks, the sub-block is address bits [5:4], so registers 15 and 16 lie in different sub-blocks.
- R6: `wr_conflict` is high, combinationally in the same cycle, exactly when two or more enabled write ports address the same sub-block.
- R7: On a conflict, only the lowest-numbered enabled port among those hitting that sub-block commits. The others leave their target registers unchanged. Writes to other sub-blocks in the same cycle still commit.
- R8: A write port whose enable is low changes no register and does not contribute to `wr_conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NWR | Write enable, one bit per write port |
| wr_addr | input | NWR*6 | Write addresses; port p uses bits [p*6 +: 6] |
| wr_data | input | NWR*64 | Write data; port p uses bits [p*64 +: 64] |
| rd_addr | input | NRD*6 | Read addresses; port r uses bits [r*6 +: 6] |
| rd_data | output | NRD*64 | Registered read data; port r uses bits [r*64 +: 64] |
| wr_conflict | output | 1 | Two or more enabled writes hit one sub-block this cycle |

## Verification
The bench targets the sub-block boundary at registers 15 and 16. A wrong index slice would either flag a false conflict there or merge two writes. It drives a read and a write of the same register at the same edge. A design with a hidden bypass or a late write would return the new value too early. On conflicting writes it checks that port 0 beats port 1, and that port 1 beats port 2 when port 0 is idle. A reversed priority or a missing drop would leave the wrong value or corrupt the losing register. It also reads one address on all five ports at once. A write that missed one replica would show up as a mismatched port.

// File: rtl/mprf_banked.sv
module mprf_banked #(
  parameter int NREG = 64,
  parameter int W    = 64,
  parameter int NWR  = 3,
  parameter int NRD  = 5,
  parameter int NSUB = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NWR-1:0]                wr_en,
  input  logic [NWR*$clog2(NREG)-1:0]   wr_addr,
  input  logic [NWR*W-1:0]              wr_data,
  input  logic [NRD*$clog2(NREG)-1:0]   rd_addr,
  output logic [NRD*W-1:0]              rd_data,
  output logic                          wr_conflict
);
  localparam int AW    = $clog2(NREG);
  localparam int SBW   = $clog2(NSUB);
  localparam int LW    = AW - SBW;
  localparam int DEPTH = NREG / NSUB;

  logic [NWR-1:0]  commit;
  logic            conflict_c;
  logic [NSUB-1:0] sb_we;
  logic [LW-1:0]   sb_idx  [NSUB];
  logic [W-1:0]    sb_wd   [NSUB];
  logic [NREG-1:0] vld;

  function automatic logic [SBW-1:0] sb_of(input logic [AW-1:0] a);
    return a[AW-1 -: SBW];
  endfunction

  always_comb begin
    commit     = '0;
    conflict_c = 1'b0;
    for (int p = 0; p < NWR; p++) begin
      commit[p] = wr_en[p];
      for (int q = 0; q < p; q++)
        if (wr_en[q] && wr_en[p] &&
            sb_of(wr_addr[q*AW +: AW]) == sb_of(wr_addr[p*AW +: AW])) begin
          commit[p]  = 1'b0;
          conflict_c = 1'b1;
        end
    end
  end
  assign wr_conflict = conflict_c;

  always_comb begin
    for (int b = 0; b < NSUB; b++) begin
      sb_we[b]  = 1'b0;
      sb_idx[b] = '0;
      sb_wd[b]  = '0;
      for (int p = NWR-1; p >= 0; p--)
        if (commit[p] && sb_of(wr_addr[p*AW +: AW]) == SBW'(b)) begin
          sb_we[b]  = 1'b1;
          sb_idx[b] = wr_addr[p*AW +: LW];
          sb_wd[b]  = wr_data[p*W +: W];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else
      for (int b = 0; b < NSUB; b++)
        if (sb_we[b]) vld[b*DEPTH + int'(sb_idx[b])] <= 1'b1;
  end

  genvar r;
  generate
    for (r = 0; r < NRD; r++) begin : g_rep
      logic [W-1:0]  bank [NSUB][DEPTH];
      logic [AW-1:0] ra;
      logic [W-1:0]  q;

      assign ra = rd_addr[r*AW +: AW];

      always_ff @(posedge clk)
        for (int b = 0; b < NSUB; b++)
          if (sb_we[b]) bank[b][sb_idx[b]] <= sb_wd[b];

      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (vld[ra])   q <= bank[sb_of(ra)][ra[LW-1:0]];
        else                q <= '0;
      end

      assign rd_data[r*W +: W] = q;
    end
  endgenerate

  logic [NRD-1:0] same_addr;
  logic [NRD-1:0] same_data;
  always_comb
    for (int i = 0; i < NRD; i++) begin
      same_addr[i] = rd_addr[i*AW +: AW] == rd_addr[0 +: AW];
      same_data[i] = rd_data[i*W +: W] == rd_data[0 +: W];
    end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);

  assert_port0_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> vld[$past(wr_addr[0 +: AW])]);

  assert_replicas_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&same_addr) |=> (&same_data));

  assert_conflict_needs_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> $countones(wr_en) >= 2);

  assert_loser_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> $countones(commit) < $countones(wr_en));

  assert_idle_no_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) < 2 |-> !wr_conflict);
endmodule

// File: tb/mprf_banked_bench.sv
`timescale 1ns/1ps
module mprf_banked_bench;
  localparam int AW = 6, W = 64, NWR = 3, NRD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NWR-1:0]    wr_en = '0;
  logic [NWR*AW-1:0] wr_addr = '0;
  logic [NWR*W-1:0]  wr_data = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*W-1:0]  rd_data;
  logic              wr_conflict;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  mprf_banked u_mprf_banked (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_conflict(wr_conflict));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int p, input int a, input logic [63:0] d);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = AW'(a);
    wr_data[p*W +: W] = d;
  endtask

  task automatic idle();
    wr_en = '0;
  endtask

  task automatic rd(input int r, input int a, input logic [63:0] exp, input string tag);
    rd_addr[r*AW +: AW] = AW'(a);
    tick();
    chk(tag, rd_data[r*W +: W], exp);
  endtask

  task automatic t_reset();
    #1 chk("R1 conflict idle", 64'(wr_conflict), 64'd0);
    for (int r = 0; r < NRD; r++) rd_addr[r*AW +: AW] = AW'(r * 13);
    tick();
    for (int r = 0; r < NRD; r++) chk("R1 reset read", rd_data[r*W +: W], 64'd0);
    rd(4, 63, 64'd0, "R1 reset read 63");
  endtask

  task automatic t_basic();
    wr(0, 5, 64'hA000_0000_0000_0005); tick(); idle();
    wr(2, 63, 64'hC000_0000_0000_003F); tick(); idle();
    rd(2, 5, 64'hA000_0000_0000_0005, "R2 read reg5");
    rd(3, 63, 64'hC000_0000_0000_003F, "R2 read reg63");
  endtask

  task automatic t_parallel();
    wr(0, 2, 64'h1); wr(1, 20, 64'h2); wr(2, 50, 64'h3);
    #1 chk("R5 no conflict distinct", 64'(wr_conflict), 64'd0);
    tick(); idle();
    wr(0, 15, 64'hF); wr(1, 16, 64'h10);
    #1 chk("R5 boundary 15/16 no conflict", 64'(wr_conflict), 64'd0);
    tick(); idle();
    rd_addr[0 +: AW] = 6'd2; rd_addr[AW +: AW] = 6'd20; rd_addr[2*AW +: AW] = 6'd50;
    tick();
    chk("R5 reg2", rd_data[0 +: W], 64'h1);
    chk("R5 reg20", rd_data[W +: W], 64'h2);
    chk("R5 reg50", rd_data[2*W +: W], 64'h3);
    rd(0, 15, 64'hF, "R5 reg15");
    rd(1, 16, 64'h10, "R5 reg16");
  endtask

  task automatic t_replica();
    for (int r = 0; r < NRD; r++) rd_addr[r*AW +: AW] = 6'd50;
    tick();
    for (int r = 0; r < NRD; r++) chk("R4 replica reg50", rd_data[r*W +: W], 64'h3);
  endtask

  task automatic t_rbw();
    wr(1, 5, 64'hBEEF);
    rd_addr[0 +: AW] = 6'd5;
    tick(); idle();
    chk("R3 old value on same-edge read", rd_data[0 +: W], 64'hA000_0000_0000_0005);
    tick();
    chk("R3 new value next read", rd_data[0 +: W], 64'hBEEF);
  endtask

  task automatic t_conflict();
    wr(0, 8, 64'h88); wr(1, 12, 64'hCC); wr(2, 30, 64'h30);
    #1 chk("R6 conflict ports0/1", 64'(wr_conflict), 64'd1);
    tick(); idle();
    #1 chk("R6 conflict clears", 64'(wr_conflict), 64'd0);
    rd(0, 8, 64'h88, "R7 port0 wins");
    rd(1, 12, 64'd0, "R7 port1 dropped");
    rd(2, 30, 64'h30, "R7 other sub-block commits");
    wr(1, 33, 64'h133); wr(2, 47, 64'h247);
    #1 chk("R6 conflict ports1/2", 64'(wr_conflict), 64'd1);
    tick(); idle();
    rd(3, 33, 64'h133, "R7 port1 beats port2");
    rd(4, 47, 64'd0, "R7 port2 dropped");
  endtask

  task automatic t_disabled();
    wr(0, 5, 64'hDEAD); wr(1, 6, 64'hDEAD);
    wr_en = 3'b000;
    #1 chk("R8 disabled no conflict", 64'(wr_conflict), 64'd0);
    tick();
    rd(1, 5, 64'hBEEF, "R8 disabled write ignored");
    rd(2, 6, 64'd0, "R8 disabled write ignored reg6");
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_parallel();
    t_replica();
    t_rbw();
    t_conflict();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule